// File: doc/BRIEF.md
# Mixed-Length Instruction Parcel Sequencer

This block sits between an instruction fetch port and a decoder. Fetch hands it 60-bit words. Each word is cut into four 15-bit parcels, and the block issues the instructions they hold one per cycle. An instruction is either short (one parcel) or long (two parcels). The opcode alone decides which: a configurable bit-map marks the long opcodes, and these are the ones that reference memory.

The block keeps a parcel position for the word it holds. For each instruction it presents the opcode, the register fields and, for a long instruction, the 18-bit address. A dedicated padding opcode is stepped over without issuing anything. A long opcode found in the second or fourth parcel cannot be legal, because a long instruction may not straddle the middle of the word or run past its end. In that case the block flags an alignment error and drops the rest of the word.

The block releases a word in the same cycle as the step that uses its last parcel. It waits whenever fetch data is not valid.

Top module: `parcel_issuer`

## Requirements
- R1: While reset is held, and after it is released with no valid word, `issue_valid`, `align_err` and `word_take` are 0. The first word after reset is read from parcel 0.
- R2: Parcel k of a word is bits [59-15k : 45-15k], so parcel 0 holds the most significant bits. In a parcel, bits [14:9] are the opcode, [8:6] the destination register, [5:3] the first source and [2:0] the second source. For a short instruction, `issue_addr` is 0.
- R3: An opcode is long when bit `opcode` of `LONG_MAP` is set. By default these are octal 50 to 57. A long instruction spans parcels p and p+1 as one 30-bit field: [29:24] opcode, [23:21] destination, [20:18] source, [17:0] address. For a long instruction, `issue_rk` is 0.
- R4: A long instruction at parcel 0 or parcel 2 issues in one cycle, and the position then advances by two. The legal mixes of four short, two long, long then two short, and two short then long all issue in word order.
- R5: The padding opcode `NOP_OP` (default octal 46) issues nothing. It uses one cycle, and the position advances by one.
- R6: A long opcode at parcel 1 or parcel 3 raises `align_err` for that one cycle and issues nothing. The word is released, and the next word starts at parcel 0.
- R7: `word_take` is 1 in exactly one cycle per word: the cycle whose step reaches the end of the word, or the cycle of an alignment error. The number of cycles a word occupies equals its number of steps.
- R8: While `word_valid` is 0, nothing issues, `word_take` stays 0 and the parcel position is held.
- R9: `issue_valid` and `align_err` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Fetch word is present |
| word_data | input | 60 | Fetch word, held until taken |
| word_take | output | 1 | Current word is consumed at this edge |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_long | output | 1 | Issued instruction is 30 bits |
| issue_opcode | output | 6 | Opcode |
| issue_ri | output | 3 | Destination register |
| issue_rj | output | 3 | First source register |
| issue_rk | output | 3 | Second source register (0 for long) |
| issue_addr | output | 18 | Address field (0 for short) |
| align_err | output | 1 | Long opcode found at an odd parcel |

## Verification
The hardest case to reach is a long opcode in the last parcel, because only the opcode bits of that parcel exist and the word must still be released cleanly. The stimulus builds one word from three short instructions followed by a parcel carrying a long opcode. It then sends a further word to show that the next word starts from parcel 0.

A stall in the middle of a word is also hard to produce. The driver drops `word_valid` for two cycles after the first step of a word. It then checks that the remaining instructions still come out in order and that the word's cycle count is unchanged.

// File: rtl/parcel_pkg.sv
// Package: shared geometry and the issued-instruction record for the parcel sequencer.
// Assumes a word holds an even number of equal parcels.
package parcel_pkg;
    localparam int WORD_W   = 60;
    localparam int PARCEL_W = 15;
    localparam int PARCELS  = WORD_W / PARCEL_W;
    localparam int POS_W    = $clog2(PARCELS);
    localparam int OP_W     = 6;
    localparam int REG_W    = 3;
    localparam int ADDR_W   = 2 * PARCEL_W - OP_W - 2 * REG_W;

    typedef struct packed {
        logic              lng;
        logic [OP_W-1:0]   op;
        logic [REG_W-1:0]  ri;
        logic [REG_W-1:0]  rj;
        logic [REG_W-1:0]  rk;
        logic [ADDR_W-1:0] addr;
    } instr_t;
endpackage

// File: rtl/parcel_select.sv
// Module: selects the parcel at the current position and the aligned
// two-parcel field of the half that contains it.
// Assumes parcel 0 is the most significant parcel of the word.
module parcel_select
    import parcel_pkg::*;
(
    input  logic [WORD_W-1:0]     word,
    input  logic [POS_W-1:0]      pos,
    output logic [PARCEL_W-1:0]   parcel,
    output logic [2*PARCEL_W-1:0] pair
);
    localparam int HALVES = PARCELS / 2;

    logic [PARCEL_W-1:0]   parcels [PARCELS];
    logic [2*PARCEL_W-1:0] pairs   [HALVES];

    // Slices the word into parcels, most significant first.
    for (genvar g = 0; g < PARCELS; g++) begin : g_parcel
        assign parcels[g] = word[WORD_W-1-g*PARCEL_W -: PARCEL_W];
    end

    // Slices the word into aligned parcel pairs.
    for (genvar h = 0; h < HALVES; h++) begin : g_pair
        assign pairs[h] = word[WORD_W-1-h*2*PARCEL_W -: 2*PARCEL_W];
    end

    // Picks the parcel at the position and the pair of the enclosing half.
    always_comb begin
        parcel = parcels[pos];
        pair   = pairs[pos[POS_W-1:1]];
    end
endmodule

// File: rtl/parcel_decode.sv
// Module: classifies the parcel at the current position as padding, short
// or long, and unpacks the fields of both formats.
// Assumes that when the position is even, the pair's upper parcel is the
// parcel itself.
module parcel_decode
    import parcel_pkg::*;
#(
    parameter logic [63:0]     LONG_MAP = 64'h0000_FF00_0000_0000,
    parameter logic [OP_W-1:0] NOP_OP   = 6'o46
)(
    input  logic [PARCEL_W-1:0]   parcel,
    input  logic [2*PARCEL_W-1:0] pair,
    output logic                  is_nop,
    output instr_t                fields
);
    logic [OP_W-1:0] op;

    // Extracts the opcode and looks up its length class.
    always_comb begin
        op     = parcel[PARCEL_W-1 -: OP_W];
        is_nop = (op == NOP_OP);
    end

    // Unpacks the short or the long layout, depending on the opcode.
    always_comb begin
        fields.op  = op;
        fields.lng = LONG_MAP[op];
        if (fields.lng) begin
            fields.ri   = pair[2*PARCEL_W-OP_W-1 -: REG_W];
            fields.rj   = pair[2*PARCEL_W-OP_W-REG_W-1 -: REG_W];
            fields.rk   = '0;
            fields.addr = pair[ADDR_W-1:0];
        end else begin
            fields.ri   = parcel[PARCEL_W-OP_W-1 -: REG_W];
            fields.rj   = parcel[PARCEL_W-OP_W-REG_W-1 -: REG_W];
            fields.rk   = parcel[REG_W-1:0];
            fields.addr = '0;
        end
    end

    // R5: the padding code must never be classed as long.
    initial begin
        p_nop_short_r5: assert (!LONG_MAP[NOP_OP]);
    end
endmodule

// File: rtl/parcel_issuer.sv
// Module: top of the sequencer. It walks the parcels of each fetched word,
// issues one instruction per cycle, steps over padding, flags misaligned
// long opcodes and releases the word once its last parcel is used.
// Assumes word_data is held stable until word_take is seen at an edge.
module parcel_issuer
    import parcel_pkg::*;
#(
    parameter logic [63:0]     LONG_MAP = 64'h0000_FF00_0000_0000,
    parameter logic [OP_W-1:0] NOP_OP   = 6'o46
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_valid,
    input  logic [WORD_W-1:0]    word_data,
    output logic                 word_take,
    output logic                 issue_valid,
    output logic                 issue_long,
    output logic [OP_W-1:0]      issue_opcode,
    output logic [REG_W-1:0]     issue_ri,
    output logic [REG_W-1:0]     issue_rj,
    output logic [REG_W-1:0]     issue_rk,
    output logic [ADDR_W-1:0]    issue_addr,
    output logic                 align_err
);
    logic [POS_W-1:0]     pos_q, pos_d;
    logic [POS_W:0]       step, reach;
    logic [PARCEL_W-1:0]  parcel;
    logic [2*PARCEL_W-1:0] pair;
    logic                 is_nop;
    instr_t               fields;

    parcel_select u_select (
        .word   (word_data),
        .pos    (pos_q),
        .parcel (parcel),
        .pair   (pair)
    );

    parcel_decode #(.LONG_MAP(LONG_MAP), .NOP_OP(NOP_OP)) u_decode (
        .parcel (parcel),
        .pair   (pair),
        .is_nop (is_nop),
        .fields (fields)
    );

    // Decides the step size, issue, error and release for this cycle.
    always_comb begin
        step        = '0;
        issue_valid = 1'b0;
        align_err   = 1'b0;
        word_take   = 1'b0;
        if (word_valid) begin
            if (is_nop) begin
                step = 1;
            end else if (fields.lng && pos_q[0]) begin
                align_err = 1'b1;
                word_take = 1'b1;
            end else begin
                issue_valid = 1'b1;
                step        = fields.lng ? 2 : 1;
            end
        end
        reach = {1'b0, pos_q} + step;
        if (word_valid && reach >= (POS_W+1)'(PARCELS)) word_take = 1'b1;
        pos_d = word_take ? '0 : reach[POS_W-1:0];
    end

    // Drives the issue fields from the decoded parcel.
    always_comb begin
        issue_long   = fields.lng;
        issue_opcode = fields.op;
        issue_ri     = fields.ri;
        issue_rj     = fields.rj;
        issue_rk     = fields.rk;
        issue_addr   = fields.addr;
    end

    // Holds the parcel position, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> (!issue_valid && !word_take && !align_err));
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(pos_q));
    p_take_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_take |=> (pos_q == '0));
    p_err_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (pos_q[0] && word_take));
    p_long_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_long) |-> !pos_q[0]);
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && align_err));
endmodule

// File: tb/parcel_issuer_tb.sv
`timescale 1ns/1ps
module parcel_issuer_tb;
    typedef struct packed {
        logic [1:0]  kind;   // 0 short, 1 long, 2 alignment error
        logic [5:0]  op;
        logic [2:0]  ri, rj, rk;
        logic [17:0] addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [59:0] word_data = '0;
    logic        word_take, issue_valid, issue_long, align_err;
    logic [5:0]  issue_opcode;
    logic [2:0]  issue_ri, issue_rj, issue_rk;
    logic [17:0] issue_addr;

    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    parcel_issuer u_dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_take(word_take), .issue_valid(issue_valid), .issue_long(issue_long),
        .issue_opcode(issue_opcode), .issue_ri(issue_ri), .issue_rj(issue_rj),
        .issue_rk(issue_rk), .issue_addr(issue_addr), .align_err(align_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [14:0] sh(input [5:0] op, input [2:0] i, input [2:0] j, input [2:0] k);
        return {op, i, j, k};
    endfunction

    function automatic logic [29:0] lg(input [5:0] op, input [2:0] i, input [2:0] j, input [17:0] a);
        return {op, i, j, a};
    endfunction

    // Long opcodes are octal 50..57 (R3); padding is octal 46 (R5).
    function automatic bit is_long(input [5:0] op);
        return op[5:3] == 3'o5;
    endfunction

    // Builds the expected events and the step count of one word from R2..R7.
    task automatic model(input [59:0] w, output int steps);
        int   pos = 0;
        exp_t e;
        steps = 0;
        while (pos < 4) begin
            logic [14:0] p  = w[59-15*pos -: 15];
            logic [5:0]  op = p[14:9];
            steps++;
            if (op == 6'o46) begin
                pos++;
            end else if (is_long(op)) begin
                if (pos % 2 == 1) begin
                    e = '{kind:2'd2, op:op, ri:0, rj:0, rk:0, addr:0};
                    q.push_back(e);
                    break;
                end else begin
                    logic [29:0] d = w[59-15*pos -: 30];
                    e = '{kind:2'd1, op:op, ri:d[23:21], rj:d[20:18], rk:0, addr:d[17:0]};
                    q.push_back(e);
                    pos += 2;
                end
            end else begin
                e = '{kind:2'd0, op:op, ri:p[8:6], rj:p[5:3], rk:p[2:0], addr:0};
                q.push_back(e);
                pos++;
            end
        end
    endtask

    // Driver: presents a word, optionally stalls after its first step, and
    // counts the cycles until the word is taken (R7, R8).
    task automatic send_word(input [59:0] w, input bit stall, input string tag);
        int exp_steps, steps;
        bit t;
        model(w, exp_steps);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        steps      = 0;
        forever begin
            #1;
            t = word_take;
            @(posedge clk);
            steps++;
            if (t) break;
            if (stall && steps == 1) begin
                @(negedge clk);
                word_valid = 1'b0;
                repeat (2) begin
                    #2;
                    check(!issue_valid && !word_take && !align_err, "R8",
                          {tag, " stall quiet"}, {issue_valid, word_take, align_err}, 0);
                    @(negedge clk);
                end
                word_valid = 1'b1;
            end
        end
        check(steps == exp_steps, "R7", {tag, " cycles per word"}, steps, exp_steps);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            word_valid = 1'b0;
            #2;
            check(!issue_valid && !word_take && !align_err, "R8", "idle quiet",
                  {issue_valid, word_take, align_err}, 0);
        end
    endtask

    // Monitor: pops the scoreboard on every issue or error event.
    always @(negedge clk) begin
        #2;
        if (mon_en && (issue_valid || align_err)) begin
            exp_t e, a;
            if (q.size() == 0) begin
                check(0, "R9", "unexpected event", {issue_valid, align_err}, 0);
            end else begin
                e = q.pop_front();
                check(!(issue_valid && align_err), "R9", "issue and error together",
                      {issue_valid, align_err}, 0);
                if (e.kind == 2'd2) begin
                    check(align_err && !issue_valid, "R6", "alignment error",
                          {issue_valid, align_err}, 2'b01);
                end else begin
                    a = '{kind:{1'b0, issue_long}, op:issue_opcode, ri:issue_ri,
                          rj:issue_rj, rk:issue_rk, addr:issue_addr};
                    check(issue_valid && a == e, e.kind == 2'd1 ? "R3" : "R2",
                          "issued fields", a, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        check(0, "R7", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!issue_valid && !word_take && !align_err, "R1", "quiet in reset",
              {issue_valid, word_take, align_err}, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        idle(2);
        // R1 R2: four short instructions, first word after reset starts at parcel 0.
        send_word({sh(6'o01,1,2,3), sh(6'o02,4,5,6), sh(6'o03,7,0,1), sh(6'o07,2,2,2)}, 0, "four short");
        // R4: two long.
        send_word({lg(6'o50,1,2,18'h00001), lg(6'o57,6,7,18'h3FFFF)}, 0, "two long");
        // R4: long then two short.
        send_word({lg(6'o53,3,4,18'h2A5A5), sh(6'o10,1,1,1), sh(6'o77,7,7,7)}, 0, "long short short");
        // R4: two short then long.
        send_word({sh(6'o20,0,1,2), sh(6'o45,3,4,5), lg(6'o55,5,0,18'h15A5A)}, 0, "short short long");
        // R5: padding aligns a long at parcel 2.
        send_word({sh(6'o11,2,3,4), sh(6'o46,7,7,7), lg(6'o51,1,0,18'h0ABCD)}, 0, "pad then long");
        // R5: a word of padding issues nothing but still takes four cycles.
        send_word({sh(6'o46,0,0,0), sh(6'o46,1,1,1), sh(6'o46,2,2,2), sh(6'o46,3,3,3)}, 0, "all pad");
        // R6: long opcode at parcel 1.
        send_word({sh(6'o04,1,2,3), lg(6'o52,1,2,18'h12345), sh(6'o05,4,4,4)}, 0, "long at p1");
        // R6: long opcode at parcel 3, then the next word starts at parcel 0.
        send_word({sh(6'o06,1,1,1), sh(6'o07,2,2,2), sh(6'o12,3,3,3), sh(6'o54,4,4,4)}, 0, "long at p3");
        send_word({sh(6'o13,5,6,7), lg(6'o56,2,3,18'h00FF0), sh(6'o14,0,0,7)}, 0, "after error");
        // R8: stall in the middle of a word.
        send_word({sh(6'o15,1,2,3), sh(6'o16,4,5,6), lg(6'o50,7,6,18'h3C3C3)}, 1, "stalled");
        idle(3);
        check(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
        finish_run();
    end
endmodule